// File: doc/BRIEF.md
# Command/Response Byte Mailbox Port

This block is the device end of a byte-wide, two-location I/O window. A host uses it to pass framed command packets to an internal engine and to collect framed response packets back. Offset 0 is the data location. Offset 1 returns a status byte when read and accepts a control code when written. The engine side sees two valid/ready byte streams: one carries command bytes out, with a last-byte marker, and one carries response bytes in.

A host transaction opens with the normal-mode code, writes payload bytes one at a time while watching the input-full flag, and closes with the end-of-command code. The response comes back through the same data location. It starts with a framing byte flagged as control, continues with payload bytes flagged as plain data, and ends with a closing control byte. The cancel code can be written at any moment and drops the port back to idle-and-ready. Illegal host accesses change nothing except the last-write-address flag, and they raise a sticky error flag toward the engine.

Because the end of a command is known only when the host writes the close code, the port holds one command byte in a lookahead stage. It presents that byte to the engine only once the next byte or the close code has arrived, so the last-byte marker is always correct.

Top module: `mbx_port`

## Requirements
- R1: A read at offset 1 returns the status byte {2'b00, IBR, RDY, A2, F0, IBF, OBF}, with OBF at bit 0, IBF at bit 1, F0 at bit 2, A2 at bit 3, RDY at bit 4 and IBR at bit 5. A read at offset 0 returns the data register. After reset the status is 0x10, the error flag is low and neither engine stream handshakes.
- R2: Writing code 0x01 at offset 1 while RDY is set clears RDY and sets IBR from the next cycle.
- R3: A data write at offset 0 that is accepted sets IBF from the next cycle. IBF clears one cycle later when the lookahead stage is free, or in the cycle the engine takes the staged byte.
- R4: A staged command byte is offered on the command stream only after a later byte or the close code 0x03 (written at offset 1 while IBR is set) has arrived. The byte offered with no successor after the close code carries cmd_last. Taking it clears IBR. A close code with no payload clears IBR two cycles after it is written.
- R5: A response is framed as 0x01 with F0 set, then each engine byte with F0 clear, then 0x03 with F0 set, each with OBF set. F0 is never set without OBF. rsp_ready is high only while OBF is clear during the payload phase.
- R6: A data read while OBF is set clears OBF and F0 from the next cycle. Reading the closing byte sets RDY.
- R7: Writing 0x22 at offset 1 gives status 0x18 and a cleared error flag from the next cycle, and empties both streams' state. In the cancel cycle neither engine stream can complete a handshake.
- R8: Each of the following is ignored and sets the sticky error flag: a data write while IBF is set, while IBR is clear, or after the close code; a data read while OBF is clear; an unknown code; 0x01 while RDY is clear; 0x03 while IBR is clear.
- R9: A2 holds the offset of the most recent host write (0 for data, 1 for control).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 1 | Offset: 0 data, 1 status/control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned for the current offset |
| cmd_valid | output | 1 | Command byte offered to engine |
| cmd_ready | input | 1 | Engine takes the command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Offered byte is the final one of the command |
| rsp_valid | input | 1 | Engine offers a response byte |
| rsp_ready | output | 1 | Port takes the response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Offered response byte is the final payload byte |
| err_flag | output | 1 | Sticky illegal-access flag, cleared by cancel |

## Verification
Two collisions matter most. The first is a cancel written in the same cycle that the engine is ready to take a staged command byte. The second is a cancel written in the same cycle that the port would take a response byte. The bench sets up each case so that the handshake would otherwise complete, then writes cancel in that exact cycle. It checks that the valid or ready line drops within the cycle and that the status reads 0x18 afterwards. It also checks that a response the engine still holds is then restarted from a fresh framing byte and not merged into the cancelled one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CODE_NORMAL = 8'h01;
  localparam byte_t CODE_EOC    = 8'h03;
  localparam byte_t CODE_CANCEL = 8'h22;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_A2  = 3;
  localparam int ST_RDY = 4;
  localparam int ST_IBR = 5;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_BODY  = 2'd1,
    RS_TRAIL = 2'd2,
    RS_END   = 2'd3
  } rsp_st_e;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_wr,
  input  logic  host_rd,
  input  logic  host_addr,
  input  byte_t host_wdata,
  input  logic  ibf,
  input  logic  obf,
  input  logic  eoc_seen,
  input  logic  cmd_done,
  input  logic  rsp_done,
  output logic  cancel,
  output logic  eoc_ok,
  output logic  dat_wr_ok,
  output logic  dat_rd_ok,
  output logic  rdy,
  output logic  ibr,
  output logic  a2,
  output logic  err
);
  logic cmd_wr, dat_wr, dat_rd, norm_ok, bad;
  logic rdy_d, ibr_d, a2_d, err_d;
  logic rdy_q, ibr_q, a2_q, err_q;

  // access decode
  always_comb begin
    cmd_wr    = host_wr & host_addr;
    dat_wr    = host_wr & ~host_addr;
    dat_rd    = host_rd & ~host_addr;
    cancel    = cmd_wr && (host_wdata == CODE_CANCEL);
    norm_ok   = cmd_wr && (host_wdata == CODE_NORMAL) && rdy_q;
    eoc_ok    = cmd_wr && (host_wdata == CODE_EOC) && ibr_q && !eoc_seen;
    dat_wr_ok = dat_wr && ibr_q && !ibf && !eoc_seen;
    dat_rd_ok = dat_rd && obf;
    bad       = (cmd_wr && !cancel && !norm_ok && !eoc_ok) ||
                (dat_wr && !dat_wr_ok) ||
                (dat_rd && !dat_rd_ok);
  end

  // next state
  always_comb begin
    rdy_d = rdy_q;
    ibr_d = ibr_q;
    a2_d  = a2_q;
    err_d = err_q;
    if (host_wr) a2_d = host_addr;
    if (cancel) begin
      rdy_d = 1'b1;
      ibr_d = 1'b0;
      err_d = 1'b0;
    end else begin
      if (rsp_done) rdy_d = 1'b1;
      if (cmd_done) ibr_d = 1'b0;
      if (norm_ok) begin
        rdy_d = 1'b0;
        ibr_d = 1'b1;
      end
      if (bad) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      ibr_q <= 1'b0;
      a2_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ibr_q <= ibr_d;
      a2_q  <= a2_d;
      err_q <= err_d;
    end
  end

  assign rdy = rdy_q;
  assign ibr = ibr_q;
  assign a2  = a2_q;
  assign err = err_q;
endmodule

// File: rtl/mbx_cmd_path.sv
module mbx_cmd_path
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cancel,
  input  logic  wr_ok,
  input  logic  eoc_ok,
  input  byte_t wdata,
  input  logic  cmd_ready,
  output logic  cmd_valid,
  output byte_t cmd_data,
  output logic  cmd_last,
  output logic  ibf,
  output logic  eoc_seen,
  output logic  cmd_done
);
  logic  ibf_q, ibf_d, stg_vld_q, stg_vld_d, eoc_q, eoc_d;
  byte_t in_q, in_d, stg_q, stg_d;
  logic  pop, move;

  always_comb begin
    cmd_valid = stg_vld_q && (ibf_q || eoc_q) && !cancel;
    cmd_last  = eoc_q && !ibf_q;
    pop       = cmd_valid && cmd_ready;
    move      = ibf_q && (!stg_vld_q || pop);
    cmd_done  = !cancel && eoc_q &&
                ((pop && cmd_last) || (!stg_vld_q && !ibf_q));
  end

  always_comb begin
    ibf_d     = ibf_q;
    stg_vld_d = stg_vld_q;
    eoc_d     = eoc_q;
    in_d      = in_q;
    stg_d     = stg_q;
    if (cancel) begin
      ibf_d     = 1'b0;
      stg_vld_d = 1'b0;
      eoc_d     = 1'b0;
    end else begin
      if (move) begin
        stg_d     = in_q;
        stg_vld_d = 1'b1;
        ibf_d     = 1'b0;
      end else if (pop) begin
        stg_vld_d = 1'b0;
      end
      if (wr_ok) begin
        in_d  = wdata;
        ibf_d = 1'b1;
      end
      if (eoc_ok)   eoc_d = 1'b1;
      if (cmd_done) eoc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q     <= 1'b0;
      stg_vld_q <= 1'b0;
      eoc_q     <= 1'b0;
      in_q      <= '0;
      stg_q     <= '0;
    end else begin
      ibf_q     <= ibf_d;
      stg_vld_q <= stg_vld_d;
      eoc_q     <= eoc_d;
      in_q      <= in_d;
      stg_q     <= stg_d;
    end
  end

  assign cmd_data = stg_q;
  assign ibf      = ibf_q;
  assign eoc_seen = eoc_q;
endmodule

// File: rtl/mbx_rsp_path.sv
module mbx_rsp_path
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cancel,
  input  logic  rd_ok,
  input  logic  rsp_valid,
  input  byte_t rsp_data,
  input  logic  rsp_last,
  output logic  rsp_ready,
  output byte_t out_byte,
  output logic  obf,
  output logic  f0,
  output logic  rsp_done
);
  rsp_st_e st_q, st_d;
  byte_t   out_q, out_d;
  logic    obf_q, obf_d, f0_q, f0_d;
  logic    take;

  always_comb begin
    rsp_ready = (st_q == RS_BODY) && !obf_q && !cancel;
    take      = rsp_ready && rsp_valid;
    rsp_done  = (st_q == RS_END) && rd_ok && !cancel;
  end

  always_comb begin
    st_d  = st_q;
    out_d = out_q;
    obf_d = obf_q;
    f0_d  = f0_q;
    if (cancel) begin
      st_d  = RS_IDLE;
      obf_d = 1'b0;
      f0_d  = 1'b0;
    end else begin
      if (rd_ok) begin
        obf_d = 1'b0;
        f0_d  = 1'b0;
      end
      unique case (st_q)
        RS_IDLE: if (rsp_valid && !obf_q) begin
          out_d = CODE_NORMAL;
          obf_d = 1'b1;
          f0_d  = 1'b1;
          st_d  = RS_BODY;
        end
        RS_BODY: if (take) begin
          out_d = rsp_data;
          obf_d = 1'b1;
          f0_d  = 1'b0;
          if (rsp_last) st_d = RS_TRAIL;
        end
        RS_TRAIL: if (!obf_q) begin
          out_d = CODE_EOC;
          obf_d = 1'b1;
          f0_d  = 1'b1;
          st_d  = RS_END;
        end
        RS_END: if (rsp_done) st_d = RS_IDLE;
        default: st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      out_q <= '0;
      obf_q <= 1'b0;
      f0_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
      obf_q <= obf_d;
      f0_q  <= f0_d;
    end
  end

  assign out_byte = out_q;
  assign obf      = obf_q;
  assign f0       = f0_q;
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_last,
  output logic              err_flag
);
  logic  cancel_now, eoc_ok, dat_wr_ok, dat_rd_ok;
  logic  rdy, ibr, a2, ibf, obf, f0, eoc_seen, cmd_done, rsp_done;
  byte_t out_byte, stat_byte;

  mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .ibf(ibf), .obf(obf),
    .eoc_seen(eoc_seen), .cmd_done(cmd_done), .rsp_done(rsp_done),
    .cancel(cancel_now), .eoc_ok(eoc_ok), .dat_wr_ok(dat_wr_ok),
    .dat_rd_ok(dat_rd_ok), .rdy(rdy), .ibr(ibr), .a2(a2), .err(err_flag)
  );

  mbx_cmd_path u_cmd (
    .clk(clk), .rst_n(rst_n), .cancel(cancel_now), .wr_ok(dat_wr_ok),
    .eoc_ok(eoc_ok), .wdata(host_wdata), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .ibf(ibf), .eoc_seen(eoc_seen), .cmd_done(cmd_done)
  );

  mbx_rsp_path u_rsp (
    .clk(clk), .rst_n(rst_n), .cancel(cancel_now), .rd_ok(dat_rd_ok),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rsp_ready(rsp_ready), .out_byte(out_byte), .obf(obf), .f0(f0),
    .rsp_done(rsp_done)
  );

  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_OBF] = obf;
    stat_byte[ST_IBF] = ibf;
    stat_byte[ST_F0]  = f0;
    stat_byte[ST_A2]  = a2;
    stat_byte[ST_RDY] = rdy;
    stat_byte[ST_IBR] = ibr;
    host_rdata        = host_addr ? stat_byte : out_byte;
  end
endmodule

// File: rtl/mbx_port_chk.sv
module mbx_port_chk
  import mbx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic        host_addr,
  input logic [7:0]  host_wdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_last,
  input logic        rsp_ready,
  input logic        err_flag,
  input logic        cancel_now,
  input logic [7:0]  stat_byte
);
  p_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && host_wdata == CODE_NORMAL && stat_byte[ST_RDY])
      |=> (stat_byte[ST_IBR] && !stat_byte[ST_RDY]));

  p_last_clears_ibr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_last && !(host_wr && host_addr))
      |=> !stat_byte[ST_IBR]);

  p_ready_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !stat_byte[ST_OBF]);

  p_f0_with_obf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[ST_F0] |-> stat_byte[ST_OBF]);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr && stat_byte[ST_OBF] && !host_wr)
      |=> (!stat_byte[ST_OBF] && !stat_byte[ST_F0]));

  p_cancel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_now |=> (stat_byte == 8'h18 && !err_flag));

  p_cancel_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_now |-> (!cmd_valid && !rsp_ready));

  p_busy_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr && stat_byte[ST_IBF]) |=> err_flag);

  p_a2_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (stat_byte[ST_A2] == $past(host_addr)));
endmodule

bind mbx_port mbx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_last(cmd_last), .rsp_ready(rsp_ready),
  .err_flag(err_flag), .cancel_now(cancel_now), .stat_byte(stat_byte)
);

// File: tb/mbx_port_tb.sv
`timescale 1ns/1ps
module mbx_port_tb;
  logic       clk, rst_n;
  logic       host_wr, host_rd, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       cmd_valid, cmd_ready, cmd_last;
  logic [7:0] cmd_data;
  logic       rsp_valid, rsp_ready, rsp_last;
  logic [7:0] rsp_data;
  logic       err_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  mbx_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic chk_status(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    hread(1'b1, s);
    chk(s == exp, tag, s, exp);
  endtask

  task automatic eng_push(input logic [7:0] d, input logic l);
    rsp_valid = 1'b1; rsp_data = d; rsp_last = l;
    #1;
    while (!rsp_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_status(8'h10, "R1 status after reset");
    chk(!err_flag && !cmd_valid && !rsp_ready, "R1 idle outputs", {err_flag, cmd_valid, rsp_ready}, 0);
  endtask

  task automatic t_command;
    hwrite(1'b1, 8'h01);
    chk_status(8'h28, "R2 normal mode sets IBR clears RDY");
    hwrite(1'b0, 8'hA0);
    host_addr = 1'b1; #1;
    chk(host_rdata == 8'h22, "R3 IBF set after data write, R9 A2=0", host_rdata, 8'h22);
    @(negedge clk); #1;
    chk(host_rdata == 8'h20, "R3 IBF clears when staged", host_rdata, 8'h20);
    chk(!cmd_valid, "R4 byte held without successor", cmd_valid, 0);
    hwrite(1'b0, 8'hA1);
    #1;
    chk(cmd_valid && cmd_data == 8'hA0 && !cmd_last, "R4 first byte offered not last",
        {cmd_valid, cmd_data, cmd_last}, {1'b1, 8'hA0, 1'b0});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    #1;
    chk(!cmd_valid, "R4 second byte held until close", cmd_valid, 0);
    hwrite(1'b1, 8'h03);
    #1;
    chk(cmd_valid && cmd_data == 8'hA1 && cmd_last, "R4 final byte marked last",
        {cmd_valid, cmd_data, cmd_last}, {1'b1, 8'hA1, 1'b1});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk_status(8'h08, "R4 IBR clears after last byte taken");
  endtask

  task automatic t_response;
    logic [7:0] got [4];
    logic       flg [4];
    logic [7:0] exp_b [4];
    logic       exp_f [4];
    exp_b = '{8'h01, 8'hB0, 8'hB1, 8'h03};
    exp_f = '{1'b1, 1'b0, 1'b0, 1'b1};
    fork
      begin
        eng_push(8'hB0, 1'b0);
        eng_push(8'hB1, 1'b1);
      end
      begin
        for (int i = 0; i < 4; i++) begin
          logic [7:0] s;
          s = 8'h00;
          for (int p = 0; p < 50 && !s[0]; p++) hread(1'b1, s);
          flg[i] = s[2];
          hread(1'b0, got[i]);
        end
      end
    join
    for (int i = 0; i < 4; i++)
      chk(got[i] == exp_b[i] && flg[i] == exp_f[i], "R5 response framing byte/F0",
          {flg[i], got[i]}, {exp_f[i], exp_b[i]});
    chk_status(8'h18, "R6 closing read sets RDY and clears OBF");
  endtask

  task automatic t_errors;
    logic [7:0] d;
    hread(1'b0, d);
    chk(err_flag, "R8 read with OBF clear flags error", err_flag, 1);
    chk_status(8'h18, "R8 empty read changes no state");
    hwrite(1'b1, 8'h22);
    chk(!err_flag, "R7 cancel clears error", err_flag, 0);
    hwrite(1'b0, 8'h44);
    chk(err_flag, "R8 data write with IBR clear flags error", err_flag, 1);
    chk_status(8'h10, "R8 write outside phase ignored, R9 A2=0");
    hwrite(1'b1, 8'h22);
    hwrite(1'b1, 8'h55);
    chk(err_flag, "R8 unknown code flags error", err_flag, 1);
    chk_status(8'h18, "R8 unknown code ignored");
    hwrite(1'b1, 8'h22);
    hwrite(1'b1, 8'h03);
    chk(err_flag, "R8 close with IBR clear flags error", err_flag, 1);
    hwrite(1'b1, 8'h22);
    hwrite(1'b1, 8'h01);
    hwrite(1'b1, 8'h03);
    chk_status(8'h28, "R4 empty command IBR still set one cycle");
    chk_status(8'h08, "R4 empty command IBR cleared");
    chk(!err_flag, "R4 empty command no error", err_flag, 0);
    hwrite(1'b1, 8'h01);
    chk(err_flag, "R8 normal mode with RDY clear flags error", err_flag, 1);
    hwrite(1'b1, 8'h22);
    hwrite(1'b1, 8'h01);
    hwrite(1'b0, 8'h5A);
    hwrite(1'b0, 8'h77);
    chk(err_flag, "R8 write with IBF set flags error", err_flag, 1);
    chk_status(8'h20, "R8 rejected write leaves IBF clear");
    hwrite(1'b1, 8'h03);
    #1;
    chk(cmd_valid && cmd_data == 8'h5A && cmd_last, "R8 rejected byte never reaches engine",
        {cmd_valid, cmd_data, cmd_last}, {1'b1, 8'h5A, 1'b1});
    hwrite(1'b1, 8'h22);
  endtask

  task automatic t_cancel_collide;
    logic [7:0] d;
    hwrite(1'b1, 8'h01);
    hwrite(1'b0, 8'h11);
    @(negedge clk);
    hwrite(1'b0, 8'h22);
    #1;
    chk(cmd_valid, "R7 setup command byte offered", cmd_valid, 1);
    cmd_ready = 1'b1; host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h22;
    #1;
    chk(!cmd_valid, "R7 cancel blocks command handshake", cmd_valid, 0);
    @(negedge clk);
    host_wr = 1'b0; cmd_ready = 1'b0;
    #1;
    chk(!cmd_valid, "R7 command stream empty after cancel", cmd_valid, 0);
    chk_status(8'h18, "R7 status after cancel on command");
    rsp_valid = 1'b1; rsp_data = 8'hC3; rsp_last = 1'b0;
    @(negedge clk);
    hread(1'b0, d);
    chk(d == 8'h01, "R5 header before collision", d, 8'h01);
    #1;
    chk(rsp_ready, "R5 ready once OBF clear", rsp_ready, 1);
    host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h22;
    #1;
    chk(!rsp_ready, "R7 cancel blocks response handshake", rsp_ready, 0);
    @(negedge clk);
    host_wr = 1'b0;
    host_addr = 1'b1; #1;
    chk(host_rdata == 8'h18, "R7 status after cancel on response", host_rdata, 8'h18);
    @(negedge clk);
    host_addr = 1'b0; #1;
    chk(host_rdata == 8'h01, "R7 held response restarts with header", host_rdata, 8'h01);
    rsp_valid = 1'b0;
    hwrite(1'b1, 8'h22);
    chk_status(8'h18, "R7 final cancel returns to idle");
  endtask

  initial begin
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    cmd_ready = 0; rsp_valid = 0; rsp_data = 0; rsp_last = 0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_command();
    t_response();
    t_errors();
    t_cancel_collide();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule